// File: doc/BRIEF.md
# Stereo DC-Offset Removal Filter with Estimate Freeze

This block sits after a decimation stage and takes out the DC offset that is carried in a stereo stream of 24-bit signed samples. Each channel keeps its own running estimate of the DC level, and the block subtracts that estimate from every sample that arrives. The estimate is a first-order leaky integrator. It is kept with 12 extra fractional bits, and each valid sample moves it one 4096th of the way toward that sample.

Each channel has its own hold input. While a channel's hold bit is high, its estimate stops moving but is still subtracted from every sample, so turning the filter off does not bypass it. A system offset calibration uses this. The filter runs with hold low until the estimate settles. Hold is then raised, and the settled offset stays fixed and keeps being removed. When hold drops again, tracking resumes from the held value.

Top module: `dc_block_filter`

## Requirements
- R1: `out_valid` is high exactly in the clock cycle after a cycle in which `in_valid` was high, and low after a cycle in which it was low.
- R2: With hold low, each valid sample x moves the estimate A (36-bit signed, 12 fractional bits) by A <= A + ((x*4096 - A) >>> 12). The arithmetic shift rounds toward minus infinity.
- R3: Each output equals x - (A >>> 12) computed with the estimate from before the update. The result is clamped to the range -8388608 to 8388607.
- R4: While a channel's hold bit is high during a valid sample, that channel's estimate does not change, and it is still subtracted from the sample.
- R5: When hold returns low, tracking continues from the held estimate, not from zero.
- R6: The two channels are independent. The left channel (`in_left`, `hold_left`, `out_left`) and the right channel (`in_right`, `hold_right`, `out_right`) do not affect each other.
- R7: Synchronous active-high reset clears both estimates and drives `out_valid` and both outputs to zero. The first sample after reset passes through unchanged, whatever the hold bits are.
- R8: In cycles without `in_valid`, the estimates and the output samples keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| hold_left | input | 1 | Freeze the left estimate (it is still subtracted) |
| hold_right | input | 1 | Freeze the right estimate (it is still subtracted) |
| out_valid | output | 1 | Output sample strobe, one clock after `in_valid` |
| out_left | output | 24 | Corrected left sample, signed |
| out_right | output | 24 | Corrected right sample, signed |

## Verification
The bench drives the estimate close to full scale in both directions and then applies a full-scale step of the opposite sign. A design that wrapped instead of clamping would output a sample of the wrong sign. It holds one channel while the other keeps tracking, then releases it. A design that bypassed the subtraction under hold, reset the estimate on release, or coupled the two channels would produce outputs that differ from the reference model. It also inserts idle gaps and resets while a hold bit is high, which exposes estimates that drift without a strobe or survive reset.

// File: rtl/dcrm_pkg.sv
package dcrm_pkg;

    localparam int SAMPLE_W = 24;
    localparam int FRAC_W   = 12;
    localparam int K_SHIFT  = 12;
    localparam int ACC_W    = SAMPLE_W + FRAC_W;
    localparam int N_CH     = 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef struct packed {
        logic                   valid;
        logic    [N_CH-1:0]     hold;
        sample_t [N_CH-1:0]     data;
    } frame_t;

    // a - b with the result clamped to the signed sample range
    function automatic sample_t sat_sub(sample_t a, sample_t b);
        logic signed [SAMPLE_W:0] d;
        d = {a[SAMPLE_W-1], a} - {b[SAMPLE_W-1], b};
        if (d[SAMPLE_W] != d[SAMPLE_W-1])
            return d[SAMPLE_W] ? {1'b1, {(SAMPLE_W-1){1'b0}}}
                               : {1'b0, {(SAMPLE_W-1){1'b1}}};
        return d[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/dcrm_estimator.sv
module dcrm_estimator #(
    parameter int SW = dcrm_pkg::SAMPLE_W,
    parameter int FW = dcrm_pkg::FRAC_W,
    parameter int KS = dcrm_pkg::K_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_en,
    input  logic                 hold,
    input  logic signed [SW-1:0] x,
    output logic signed [SW-1:0] est_o
);
    localparam int AW = SW + FW;

    logic signed [AW-1:0] acc_q;
    logic signed [AW:0]   target;
    logic signed [AW:0]   diff;
    logic signed [AW:0]   step;

    always_comb begin
        target = $signed({x[SW-1], x, {FW{1'b0}}});
        diff   = target - $signed({acc_q[AW-1], acc_q});
        step   = diff >>> KS;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (step_en && !hold)
            acc_q <= acc_q + step[AW-1:0];
    end

    assign est_o = acc_q[AW-1:FW];
endmodule

// File: rtl/dcrm_correct.sv
module dcrm_correct (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  dcrm_pkg::sample_t x,
    input  dcrm_pkg::sample_t est,
    output dcrm_pkg::sample_t y
);
    dcrm_pkg::sample_t y_q;

    always_ff @(posedge clk) begin
        if (rst)
            y_q <= '0;
        else if (load)
            y_q <= dcrm_pkg::sat_sub(x, est);
    end

    assign y = y_q;
endmodule

// File: rtl/dc_block_filter.sv
module dc_block_filter
    import dcrm_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic                       hold_left,
    input  logic                       hold_right,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right
);
    frame_t             in_frame;
    sample_t [N_CH-1:0] est;
    sample_t [N_CH-1:0] y;
    sample_t            est_left;
    sample_t            est_right;
    logic               valid_q;

    assign in_frame.valid   = in_valid;
    assign in_frame.hold    = {hold_right, hold_left};
    assign in_frame.data[0] = in_left;
    assign in_frame.data[1] = in_right;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dcrm_estimator #(
            .SW(SAMPLE_W), .FW(FRAC_W), .KS(K_SHIFT)
        ) u_est (
            .clk    (clk),
            .rst    (rst),
            .step_en(in_frame.valid),
            .hold   (in_frame.hold[c]),
            .x      (in_frame.data[c]),
            .est_o  (est[c])
        );

        dcrm_correct u_cor (
            .clk (clk),
            .rst (rst),
            .load(in_frame.valid),
            .x   (in_frame.data[c]),
            .est (est[c]),
            .y   (y[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= in_frame.valid;
    end

    assign est_left  = est[0];
    assign est_right = est[1];
    assign out_valid = valid_q;
    assign out_left  = y[0];
    assign out_right = y[1];
endmodule

// File: rtl/dcrm_checker.sv
module dcrm_checker #(
    parameter int SW = dcrm_pkg::SAMPLE_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 hold_left,
    input logic                 hold_right,
    input logic                 out_valid,
    input logic signed [SW-1:0] out_left,
    input logic signed [SW-1:0] out_right,
    input logic signed [SW-1:0] est_left,
    input logic signed [SW-1:0] est_right
);
    // R1: strobe latency of one clock
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4: frozen estimates stay put on valid samples
    a_r4_freeze_left: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hold_left) |=> $stable(est_left));
    a_r4_freeze_right: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hold_right) |=> $stable(est_right));

    // R8: idle cycles change nothing
    a_r8_est_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(est_left) && $stable(est_right)));
    a_r8_out_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));

    // R7: reset leaves cleared state behind
    a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (est_left == '0 && est_right == '0 && !out_valid
                        && out_left == '0 && out_right == '0));
endmodule

bind dc_block_filter dcrm_checker #(.SW(dcrm_pkg::SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .hold_left (hold_left),
    .hold_right(hold_right),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .est_left  (est_left),
    .est_right (est_right)
);

// File: tb/dc_block_filter_test.sv
module dc_block_filter_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [23:0] in_left = '0;
    logic signed [23:0] in_right = '0;
    logic               hold_left = 1'b0;
    logic               hold_right = 1'b0;
    logic               out_valid;
    logic signed [23:0] out_left;
    logic signed [23:0] out_right;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int    l;
        int    r;
        string tag;
    } exp_t;

    exp_t   sb[$];
    longint macc[2];

    always #10 clk = ~clk;

    dc_block_filter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .hold_left(hold_left), .hold_right(hold_right),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic int clamp(longint v);
        if (v > 8388607)  return 8388607;
        if (v < -8388608) return -8388608;
        return int'(v);
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // driver: one valid sample per call, expected result pushed to the scoreboard
    task automatic push(int xl, int xr, bit hl, bit hr, string tag);
        exp_t e;
        int   xs[2];
        bit   hs[2];
        @(negedge clk);
        in_valid = 1'b1; in_left = 24'(xl); in_right = 24'(xr);
        hold_left = hl; hold_right = hr;
        xs[0] = xl; xs[1] = xr; hs[0] = hl; hs[1] = hr;
        e.tag = tag;
        e.l = clamp(longint'(xs[0]) - (macc[0] >>> 12));
        e.r = clamp(longint'(xs[1]) - (macc[1] >>> 12));
        for (int c = 0; c < 2; c++)
            if (!hs[c]) macc[c] = macc[c] + (((longint'(xs[c]) * 4096) - macc[c]) >>> 12);
        sb.push_back(e);
    endtask

    // monitor: compare each produced sample with the oldest expectation
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(out_left) == e.l, e.tag, "left", out_left, e.l);
                check(int'(out_right) == e.r, e.tag, "right", out_right, e.r);
            end
        end
    end

    task automatic idle(int n);
        int rl, rr;
        @(negedge clk);
        in_valid = 1'b0;
        rl = out_left; rr = out_right;
        repeat (n) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", "out_valid in gap", out_valid, 0);
            check(int'(out_left) == rl && int'(out_right) == rr, "R8", "held left output",
                  out_left, rl);
        end
        check(sb.size() == 0, "R1", "missing outputs", sb.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", "valid in reset", out_valid, 0);
        check(out_left == 0 && out_right == 0, "R7", "outputs in reset", out_left, 0);
        macc[0] = 0; macc[1] = 0;
        rst = 1'b0;
    endtask

    initial begin
        macc[0] = 0; macc[1] = 0;
        do_reset();
        // R7: first sample passes through unchanged
        push(1000, -2000, 1'b0, 1'b0, "R7");
        idle(2);
        // R2: track a DC level with noise on each channel
        for (int i = 0; i < 20000; i++)
            push(50000 + int'($urandom_range(2000)) - 1000,
                 -30000 + int'($urandom_range(600)) - 300, 1'b0, 1'b0, "R2");
        idle(5);
        // R8: estimate unchanged by the gap, outputs continue to match
        for (int i = 0; i < 50; i++)
            push(50000, -30000, 1'b0, 1'b0, "R8");
        // R4 and R6: left frozen and still subtracted while right tracks a new level
        for (int i = 0; i < 3000; i++)
            push(200000, 7000, 1'b1, 1'b0, "R4_R6");
        // R6: right frozen and left tracking
        for (int i = 0; i < 1000; i++)
            push(-5000, 90000, 1'b0, 1'b1, "R6");
        // R5: release, tracking resumes from the held values
        for (int i = 0; i < 3000; i++)
            push(120000, 90000, 1'b0, 1'b0, "R5");
        idle(3);
        // R3: estimates near full scale, then opposite full-scale steps saturate
        for (int i = 0; i < 40000; i++)
            push(-8388608, 8388607, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 8; i++)
            push(8388607, -8388608, 1'b1, 1'b1, "R3");
        push(0, 0, 1'b1, 1'b1, "R3");
        idle(2);
        // R7: reset with holds active clears the estimates
        do_reset();
        push(-123456, 654321, 1'b1, 1'b1, "R7");
        push(777, -777, 1'b1, 1'b1, "R7");
        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule